// File: doc/BRIEF.md
# Serial-Clock Pulse-Pattern Reset Detector

This block lets a host reset a serial peripheral using only its serial clock line. While the peripheral is a clocked follower (slave), the host can hold the serial clock high for three long stretches of set lengths, with a short low gap between each. The block times each high stretch and each low gap in system-clock cycles. When all three stretches fall inside their windows, it raises a one-cycle reset pulse. It then holds a lockout flag for a long fixed interval. During that interval the rest of the peripheral refuses serial traffic while its registers settle back to their defaults.

The serial clock passes through a two-stage synchronizer. One saturating counter measures the run length of the current level. A small state machine steps through the three high stretches and the two gaps between them. A stretch that falls outside its window sends the machine back to idle, where it waits for a fresh first stretch. Detection is armed only while three conditions hold together: the follower-mode input is high, the chip select is low, and the result-ready line is high (meaning no unread result is pending). A separate down-counting timer sets the length of the lockout.

Top module: `sclk_pattern_reset`

## Requirements
- R1: While `rst_n` is low, and after its release until a full pattern is seen, `soft_rst_pulse` and `comm_lockout` are both 0.
- R2: The first high stretch is accepted only if it lasts more than 256 and fewer than 400 sampled cycles. A stretch of 257 or 399 is accepted. A stretch of 256 or 400 is rejected.
- R3: The second high stretch is accepted only if it lasts more than 512 and fewer than 900 sampled cycles. A stretch of 513 or 899 is accepted. A stretch of 512 or 900 is rejected.
- R4: When the third high stretch reaches 1024 sampled cycles, `soft_rst_pulse` goes high for exactly one cycle. It goes high three clock edges after the edge that samples the 1024th high level. A third stretch of exactly 1024 still produces the pulse.
- R5: A third high stretch that ends before 1024 cycles produces no pulse.
- R6: Each low gap between stretches must last more than 5 sampled cycles. A gap of 5 aborts the pattern. A gap of 6 is accepted.
- R7: The detector is armed only while `is_slave`=1, `chip_sel_n`=0 and `result_ready_n`=1. If any of these drops at any point before the pulse, the pattern is abandoned, and it is never recognised while the detector is disarmed.
- R8: `comm_lockout` rises in the same cycle as the reset pulse and stays high for exactly LOCK_CYCLES cycles (59000 by default). Serial clock activity during the lockout produces no further pulse.
- R9: After any rejection, the detector waits for a new first stretch. A valid pattern that immediately follows a rejected stretch is recognised.
- R10: The run-length counter saturates. A first high stretch of 4396 cycles is rejected, even though a 12-bit counter that wrapped would read 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all widths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial clock line being watched |
| chip_sel_n | input | 1 | Active-low chip select; must be low to arm detection |
| result_ready_n | input | 1 | Result-ready line; must be high (no unread result) to arm detection |
| is_slave | input | 1 | 1 when the peripheral runs as a serial follower |
| soft_rst_pulse | output | 1 | One-cycle reset request when the pattern completes |
| comm_lockout | output | 1 | High while serial communication must be refused after the reset |

## Verification
The hardest condition to reach from the ports is a wrapped counter that makes an over-long stretch look legal. The stimulus holds the first stretch high for 4096 + 300 cycles and then follows it with an otherwise valid pattern, so only saturation stops a false reset. Window edges are hit one cycle inside and one cycle outside each limit. A full valid pattern is also replayed in the middle of the 59000-cycle lockout to show that the lockout swallows it. A behavioural model of the pattern rules, built on plain integers, is compared with both outputs on every clock.

// File: rtl/rstpat_pkg.sv
package rstpat_pkg;

  // Progress through the clock-width pattern
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HI1  = 3'd1,
    ST_LO1  = 3'd2,
    ST_HI2  = 3'd3,
    ST_LO2  = 3'd4,
    ST_HI3  = 3'd5,
    ST_LOCK = 3'd6
  } det_state_e;

endpackage

// File: rtl/rstpat_rst_sync.sv
module rstpat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/rstpat_level_sync.sv
module rstpat_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  output logic rise,
  output logic fall
);

  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;
  logic            lvl;
  logic            prev;

  always_comb pipe_d = {pipe_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/rstpat_run_counter.sv
module rstpat_run_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         restart,
  output logic [W-1:0] run
);

  localparam logic [W-1:0] SAT = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] run_q;
  logic [W-1:0] run_d;
  logic         at_sat;

  assign at_sat = (run_q == SAT);

  always_comb begin
    if (restart)     run_d = ONE;
    else if (at_sat) run_d = run_q;
    else             run_d = run_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign run = run_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (at_sat && !restart) |=> (run_q == SAT));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !restart |=> (run_q >= $past(run_q)));

endmodule

// File: rtl/rstpat_lock_timer.sv
module rstpat_lock_timer #(
  parameter int CYCLES = 59000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  output logic active,
  output logic last
);

  localparam int LW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [LW-1:0] END_CNT = LW'(CYCLES - 1);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_d;
  logic          act_q;
  logic          act_d;
  logic          en;

  assign last = act_q && (cnt_q == END_CNT);
  assign en   = start | act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (last) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  // R8
  lock_end_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (last && !start) |=> !active);

endmodule

// File: rtl/sclk_pattern_reset.sv
module sclk_pattern_reset
  import rstpat_pkg::*;
#(
  parameter int P1_LO       = 256,
  parameter int P1_HI       = 400,
  parameter int P2_LO       = 512,
  parameter int P2_HI       = 900,
  parameter int P3_FIRE     = 1024,
  parameter int GAP_MIN     = 5,
  parameter int LOCK_CYCLES = 59000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic chip_sel_n,
  input  logic result_ready_n,
  input  logic is_slave,
  output logic soft_rst_pulse,
  output logic comm_lockout
);

  // Counter must reach the firing length; one extra bit of headroom
  localparam int CNT_W = $clog2(P3_FIRE + 1) + 1;
  localparam logic [CNT_W-1:0] K_P1_LO = CNT_W'(P1_LO);
  localparam logic [CNT_W-1:0] K_P1_HI = CNT_W'(P1_HI);
  localparam logic [CNT_W-1:0] K_P2_LO = CNT_W'(P2_LO);
  localparam logic [CNT_W-1:0] K_P2_HI = CNT_W'(P2_HI);
  localparam logic [CNT_W-1:0] K_FIRE  = CNT_W'(P3_FIRE);
  localparam logic [CNT_W-1:0] K_GAP   = CNT_W'(GAP_MIN);

  logic             rst_s;
  logic             sc_rise;
  logic             sc_fall;
  logic [CNT_W-1:0] run;
  logic             lock_active;
  logic             lock_last;
  logic             enable;
  logic             win1_ok;
  logic             win2_ok;
  logic             gap_ok;
  logic             fire;
  det_state_e       state_q;
  det_state_e       state_d;
  logic             pulse_q;

  rstpat_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  rstpat_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_s),
    .din    (ser_clk),
    .rise   (sc_rise),
    .fall   (sc_fall)
  );

  rstpat_run_counter #(.W(CNT_W)) u_run (
    .clk     (clk),
    .rst_ni  (rst_s),
    .restart (sc_rise | sc_fall),
    .run     (run)
  );

  rstpat_lock_timer #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_ni (rst_s),
    .start  (fire),
    .active (lock_active),
    .last   (lock_last)
  );

  assign enable  = is_slave & ~chip_sel_n & result_ready_n;
  assign win1_ok = (run > K_P1_LO) && (run < K_P1_HI);
  assign win2_ok = (run > K_P2_LO) && (run < K_P2_HI);
  assign gap_ok  = (run > K_GAP);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (state_q == ST_LOCK) begin
      if (lock_last) state_d = ST_IDLE;
    end else if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (sc_rise) state_d = ST_HI1;
        ST_HI1:  if (sc_fall) state_d = win1_ok ? ST_LO1 : ST_IDLE;
        ST_LO1:  if (sc_rise) state_d = gap_ok  ? ST_HI2 : ST_IDLE;
        ST_HI2:  if (sc_fall) state_d = win2_ok ? ST_LO2 : ST_IDLE;
        ST_LO2:  if (sc_rise) state_d = gap_ok  ? ST_HI3 : ST_IDLE;
        ST_HI3: begin
          if (run >= K_FIRE) begin
            fire    = 1'b1;
            state_d = ST_LOCK;
          end else if (sc_fall) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= fire;
    end
  end

  assign soft_rst_pulse = pulse_q;
  assign comm_lockout   = (state_q == ST_LOCK);

  // R4
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_s)
    soft_rst_pulse |=> !soft_rst_pulse);

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    soft_rst_pulse |-> ($past(state_q) == ST_HI3));

  // R8
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_s)
    soft_rst_pulse |-> (comm_lockout && !$past(comm_lockout)));

  // R8
  lock_agree_chk: assert property (@(posedge clk) disable iff (!rst_s)
    lock_active == comm_lockout);

  // R7
  disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!enable && state_q != ST_LOCK) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sim_sclk_pattern_reset.sv
module sim_sclk_pattern_reset;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK_LEN   = 59000;

  logic clk;
  logic rst_n;
  logic ser_clk;
  logic chip_sel_n;
  logic result_ready_n;
  logic is_slave;
  logic soft_rst_pulse;
  logic comm_lockout;

  int checks = 0;
  int errors = 0;
  int pulse_seen = 0;
  int pulse_width = 0;
  int max_pulse_width = 0;
  int lock_run = 0;
  int last_lock_len = 0;

  // behavioural reference
  int m_s1, m_s2, m_s3, m_run, m_phase, m_left;
  int m_pulse, m_lock;

  sclk_pattern_reset u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ser_clk        (ser_clk),
    .chip_sel_n     (chip_sel_n),
    .result_ready_n (result_ready_n),
    .is_slave       (is_slave),
    .soft_rst_pulse (soft_rst_pulse),
    .comm_lockout   (comm_lockout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_run = 0;
      m_phase = 0; m_left = 0; m_pulse = 0; m_lock = 0;
    end else begin
      int en;
      int rs;
      int fl;
      int fired;
      en = (is_slave && !chip_sel_n && result_ready_n) ? 1 : 0;
      rs = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      fl = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
      fired = 0;
      if (m_phase == 6) begin
        m_left = m_left - 1;
        if (m_left == 0) m_phase = 0;
      end else if (en == 0) begin
        m_phase = 0;
      end else begin
        case (m_phase)
          0: if (rs != 0) m_phase = 1;
          1: if (fl != 0) m_phase = (m_run > 256 && m_run < 400) ? 2 : 0;
          2: if (rs != 0) m_phase = (m_run > 5) ? 3 : 0;
          3: if (fl != 0) m_phase = (m_run > 512 && m_run < 900) ? 4 : 0;
          4: if (rs != 0) m_phase = (m_run > 5) ? 5 : 0;
          default: begin
            if (m_run >= 1024) begin
              fired = 1; m_phase = 6; m_left = LOCK_LEN;
            end else if (fl != 0) begin
              m_phase = 0;
            end
          end
        endcase
      end
      m_pulse = fired;
      m_lock  = (m_phase == 6) ? 1 : 0;
      m_run = (m_s2 != m_s3) ? 1 : m_run + 1;
      m_s3 = m_s2;
      m_s2 = m_s1;
      m_s1 = ser_clk ? 1 : 0;
    end
  end

  // per-cycle comparison and port-level bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (int'(soft_rst_pulse) != m_pulse) begin
        errors++;
        $display("FAIL R4 soft_rst_pulse at %0t: act=%0d exp=%0d", $time, soft_rst_pulse, m_pulse);
      end
      if (int'(comm_lockout) != m_lock) begin
        errors++;
        $display("FAIL R8 comm_lockout at %0t: act=%0d exp=%0d", $time, comm_lockout, m_lock);
      end
    end
    if (soft_rst_pulse) begin
      pulse_seen++;
      pulse_width++;
      if (pulse_width > max_pulse_width) max_pulse_width = pulse_width;
    end else begin
      pulse_width = 0;
    end
    if (comm_lockout) lock_run++;
    else if (lock_run > 0) begin
      last_lock_len = lock_run;
      lock_run = 0;
    end
  end

  task automatic hold(input logic lvl, input int n);
    ser_clk = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic seq(input int a, input int g1, input int b, input int g2, input int c);
    hold(1'b1, a); hold(1'b0, g1); hold(1'b1, b); hold(1'b0, g2); hold(1'b1, c); hold(1'b0, 20);
  endtask

  task automatic check_int(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_lock_end();
    while (comm_lockout) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; ser_clk = 1'b0; chip_sel_n = 1'b0;
    result_ready_n = 1'b1; is_slave = 1'b1;
    @(negedge clk);
    // R1 during reset
    check_int(int'(soft_rst_pulse), 0, "R1", "pulse in reset");
    check_int(int'(comm_lockout), 0, "R1", "lockout in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 after release
    check_int(int'(soft_rst_pulse), 0, "R1", "pulse after release");
    check_int(int'(comm_lockout), 0, "R1", "lockout after release");

    base = pulse_seen; seq(256, 6, 600, 6, 1100);
    check_int(pulse_seen - base, 0, "R2", "first stretch 256");
    base = pulse_seen; seq(400, 6, 600, 6, 1100);
    check_int(pulse_seen - base, 0, "R2", "first stretch 400");
    base = pulse_seen; seq(300, 6, 512, 6, 1100);
    check_int(pulse_seen - base, 0, "R3", "second stretch 512");
    base = pulse_seen; seq(300, 6, 900, 6, 1100);
    check_int(pulse_seen - base, 0, "R3", "second stretch 900");
    base = pulse_seen; seq(300, 6, 600, 6, 1023);
    check_int(pulse_seen - base, 0, "R5", "third stretch 1023");
    base = pulse_seen; seq(300, 5, 600, 6, 1100);
    check_int(pulse_seen - base, 0, "R6", "first gap 5");
    base = pulse_seen; seq(300, 6, 600, 5, 1100);
    check_int(pulse_seen - base, 0, "R6", "second gap 5");

    // R7 chip select lifted mid second stretch
    base = pulse_seen;
    hold(1'b1, 300); hold(1'b0, 6);
    ser_clk = 1'b1;
    repeat (300) @(negedge clk);
    chip_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    chip_sel_n = 1'b0;
    repeat (297) @(negedge clk);
    hold(1'b0, 6); hold(1'b1, 1100); hold(1'b0, 20);
    check_int(pulse_seen - base, 0, "R7", "chip select abort");

    base = pulse_seen; is_slave = 1'b0;
    seq(300, 6, 600, 6, 1100);
    is_slave = 1'b1;
    check_int(pulse_seen - base, 0, "R7", "not follower mode");

    base = pulse_seen; result_ready_n = 1'b0;
    seq(300, 6, 600, 6, 1100);
    result_ready_n = 1'b1;
    check_int(pulse_seen - base, 0, "R7", "result pending");

    base = pulse_seen; seq(4396, 6, 600, 6, 1100);
    check_int(pulse_seen - base, 0, "R10", "saturated first stretch");

    // R2 R3 R4 inner boundaries, third exactly 1024
    base = pulse_seen; max_pulse_width = 0;
    seq(257, 6, 899, 6, 1024);
    check_int(pulse_seen - base, 1, "R4", "valid pattern pulse");
    check_int(max_pulse_width, 1, "R4", "pulse width");
    check_int(int'(comm_lockout), 1, "R8", "lockout after pulse");
    // R8 pattern inside lockout ignored
    seq(300, 6, 600, 6, 1100);
    wait_lock_end();
    check_int(pulse_seen - base, 1, "R8", "pattern during lockout");
    check_int(last_lock_len, LOCK_LEN, "R8", "lockout length");

    // R9 rejected stretch then valid pattern, R6 gap 7/6 accepted
    base = pulse_seen;
    hold(1'b1, 400); hold(1'b0, 10);
    seq(399, 7, 513, 6, 1100);
    check_int(pulse_seen - base, 1, "R9", "recovery after reject");
    wait_lock_end();
    check_int(last_lock_len, LOCK_LEN, "R8", "second lockout length");
    check_int(int'(soft_rst_pulse), 0, "R9", "idle after lockout");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule